// File: doc/BRIEF.md
# Vertical Pattern Repetition Sequencer

This block steps a vertical-clock pattern through the lines of a sweep region in an image sensor timing chain. Each line boundary inside an active region launches one repetition. Normally that repetition uses the main pattern A. One programmed repetition can use an alternate pattern instead: B, C or D. Downstream waveform generators read the pattern code and the repetition number. They begin toggling on a one-cycle start pulse.

The repetition count is programmed per region. A three-bit enable field chooses which alternate may take part. Each alternate has its own register for the repetition index it replaces. If more than one enable bit is set, the lowest set bit wins and the other alternates are ignored. The alternate shares its line start position with pattern A, so swapping it in needs no change to timing inside the line. Once the programmed count has been used up, the block stops issuing repetitions. It starts again when a field starts or when the region is entered again.

Top module: `vrep_sequencer`

## Requirements
- R1: While `rst` is high, and on the first sampled edge after it, `pat_id` reads 0 (idle), `rep_num` reads 0 and `rep_start` reads 0.
- R2: The first `line_strobe` edge in an active region (or after a field start) sets `rep_num` to 1 when `cfg_total_reps` is non-zero. Each later `line_strobe` edge adds 1, up to `cfg_total_reps`.
- R3: Pattern codes on `pat_id` are 0 idle, 1 A, 2 B, 3 C and 4 D. A repetition not replaced by an alternate shows code 1.
- R4: Once `rep_num` equals `cfg_total_reps`, further `line_strobe` edges give no start pulse. They set `pat_id` to idle and leave `rep_num` unchanged. With a total of 0, no repetition is ever issued.
- R5: `rep_start` is high for exactly the one cycle that follows the clock edge that sampled a `line_strobe` launching a repetition, and is low otherwise.
- R6: `pat_id` and `rep_num` change only on a clock edge that samples `line_strobe`, except when reset, a field start or a region drop returns them to idle and 0.
- R7: The winning alternate replaces exactly the repetition whose number equals its index register. All other repetitions use pattern A.
- R8: Among the enable bits (bit 0 B, bit 1 C, bit 2 D), only the lowest set bit names an alternate that can be inserted. Higher set bits have no effect, even when their index matches another repetition.
- R9: An alternate whose index is 0, or larger than `cfg_total_reps`, is never inserted.
- R10: `field_strobe`, or `region_active` low, returns the outputs to idle and 0 on the next edge. The following `line_strobe` in an active region restarts at repetition 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_strobe | input | 1 | Line-start strobe, one cycle |
| field_strobe | input | 1 | Field-start strobe, one cycle |
| region_active | input | 1 | High while the sweep region is in progress |
| cfg_total_reps | input | REP_W | Number of repetitions in the region |
| cfg_alt_en | input | 3 | Alternate enables: bit 0 B, bit 1 C, bit 2 D |
| cfg_idx_b | input | REP_W | Repetition replaced by B |
| cfg_idx_c | input | REP_W | Repetition replaced by C |
| cfg_idx_d | input | REP_W | Repetition replaced by D |
| pat_id | output | 3 | Current pattern code (0 idle, 1 A, 2 B, 3 C, 4 D) |
| rep_num | output | REP_W | Current repetition number, 1-based, 0 when idle |
| rep_start | output | 1 | One-cycle pulse that launches a repetition |

## Verification
The bench builds the block with `REP_W` = 4. This lets random totals cover the full range up to 15, including the saturating count at the top. Random alternate indices cover 0, values inside the range and values past the programmed total. Every cycle is compared against a model built from the requirements. Directed runs add priority among overlapping enables, restarts from a field start and regions with a total of zero.

// File: rtl/vrep_pkg.sv
package vrep_pkg;

    localparam int NUM_ALT = 3;

    typedef enum logic [2:0] {
        PAT_IDLE = 3'd0,
        PAT_A    = 3'd1,
        PAT_B    = 3'd2,
        PAT_C    = 3'd3,
        PAT_D    = 3'd4
    } pat_e;

    // isolate lowest set bit: fixed priority, bit 0 strongest
    function automatic logic [NUM_ALT-1:0] lowest_grant(input logic [NUM_ALT-1:0] en);
        return en & (~en + 1'b1);
    endfunction

    function automatic pat_e alt_code(input int slot);
        case (slot)
            0:       return PAT_B;
            1:       return PAT_C;
            default: return PAT_D;
        endcase
    endfunction

endpackage

// File: rtl/vrep_rep_counter.sv
module vrep_rep_counter #(
    parameter int REP_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hd,
    input  logic             vd,
    input  logic             region,
    input  logic [REP_W-1:0] total,
    output logic [REP_W-1:0] cnt_q,
    output logic [REP_W-1:0] next_num,
    output logic             issue
);

    logic armed_q;
    logic live;

    assign live     = region && !vd;
    assign next_num = armed_q ? REP_W'(1) : cnt_q + 1'b1;

    always_comb begin
        issue = 1'b0;
        if (hd && live) begin
            if (armed_q) issue = (total != '0);
            else         issue = (cnt_q < total);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !live) begin
            armed_q <= 1'b1;
            cnt_q   <= '0;
        end else if (hd) begin
            armed_q <= 1'b0;
            if (issue) cnt_q <= next_num;
        end
    end

    p_first_is_one_r2: assert property (@(posedge clk) disable iff (rst)
        (hd && live && armed_q && total != '0) |=> (cnt_q == REP_W'(1)));

    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (hd && live && !armed_q && cnt_q < total) |=> (cnt_q == $past(cnt_q) + 1'b1));

    p_hold_at_total_r4: assert property (@(posedge clk) disable iff (rst)
        (hd && live && !armed_q && cnt_q >= total) |=> $stable(cnt_q));

endmodule

// File: rtl/vrep_alt_select.sv
module vrep_alt_select
    import vrep_pkg::*;
#(
    parameter int REP_W = 8
) (
    input  logic [NUM_ALT-1:0]            en,
    input  logic [NUM_ALT-1:0][REP_W-1:0] idx,
    input  logic [REP_W-1:0]              num,
    output pat_e                          sel
);

    logic [NUM_ALT-1:0] grant;
    logic [NUM_ALT-1:0] hit;

    assign grant = lowest_grant(en);

    for (genvar g = 0; g < NUM_ALT; g++) begin : g_slot
        assign hit[g] = grant[g] && (idx[g] == num) && (num != '0);
    end

    always_comb begin
        sel = PAT_A;
        for (int i = 0; i < NUM_ALT; i++) begin
            if (hit[i]) sel = alt_code(i);
        end
    end

    // only the single granted alternate may match (R8)
    always_comb begin
        a_single_hit_r8: assert ($onehot0(hit));
    end

endmodule

// File: rtl/vrep_out_stage.sv
module vrep_out_stage
    import vrep_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hd,
    input  logic vd,
    input  logic region,
    input  logic issue,
    input  pat_e sel,
    output pat_e pat_q,
    output logic start_q
);

    always_ff @(posedge clk) begin
        if (rst || vd || !region) begin
            pat_q   <= PAT_IDLE;
            start_q <= 1'b0;
        end else begin
            start_q <= issue;
            if (hd) pat_q <= issue ? sel : PAT_IDLE;
        end
    end

    p_pulse_after_hd_r5: assert property (@(posedge clk) disable iff (rst)
        start_q |-> $past(hd && region && !vd));

    p_start_has_pattern_r4: assert property (@(posedge clk) disable iff (rst)
        start_q |-> (pat_q != PAT_IDLE));

    p_pat_only_at_hd_r6: assert property (@(posedge clk) disable iff (rst)
        (!hd && region && !vd) |=> $stable(pat_q));

endmodule

// File: rtl/vrep_sequencer.sv
module vrep_sequencer
    import vrep_pkg::*;
#(
    parameter int REP_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_strobe,
    input  logic             field_strobe,
    input  logic             region_active,
    input  logic [REP_W-1:0] cfg_total_reps,
    input  logic [2:0]       cfg_alt_en,
    input  logic [REP_W-1:0] cfg_idx_b,
    input  logic [REP_W-1:0] cfg_idx_c,
    input  logic [REP_W-1:0] cfg_idx_d,
    output logic [2:0]       pat_id,
    output logic [REP_W-1:0] rep_num,
    output logic             rep_start
);

    logic [NUM_ALT-1:0][REP_W-1:0] idx_vec;
    logic [REP_W-1:0]              next_num;
    logic                          issue;
    pat_e                          sel;
    pat_e                          pat_q;

    assign idx_vec = {cfg_idx_d, cfg_idx_c, cfg_idx_b};

    vrep_rep_counter #(.REP_W(REP_W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .hd       (line_strobe),
        .vd       (field_strobe),
        .region   (region_active),
        .total    (cfg_total_reps),
        .cnt_q    (rep_num),
        .next_num (next_num),
        .issue    (issue)
    );

    vrep_alt_select #(.REP_W(REP_W)) u_select (
        .en  (cfg_alt_en),
        .idx (idx_vec),
        .num (next_num),
        .sel (sel)
    );

    vrep_out_stage u_out (
        .clk     (clk),
        .rst     (rst),
        .hd      (line_strobe),
        .vd      (field_strobe),
        .region  (region_active),
        .issue   (issue),
        .sel     (sel),
        .pat_q   (pat_q),
        .start_q (rep_start)
    );

    assign pat_id = pat_q;

    p_rep_zero_when_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (field_strobe || !region_active) |=> (rep_num == '0 && pat_id == 3'd0));

endmodule

// File: tb/vrep_sequencer_bench.sv
`timescale 1ns/1ps
module vrep_sequencer_bench;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         hd = 1'b0, vd = 1'b0, reg_act = 1'b0;
    logic [W-1:0] total = '0, ib = '0, ic = '0, id = '0;
    logic [2:0]   en = '0;
    logic [2:0]   pat_id;
    logic [W-1:0] rep_num;
    logic         rep_start;

    int checks = 0, fails = 0;
    bit finished = 0;

    // model state
    bit           m_armed = 1;
    int           m_cnt = 0, m_pat = 0;
    bit           m_st = 0;
    int           seen [0:15];
    int           pulses = 0;

    vrep_sequencer #(.REP_W(W)) u_vrep_sequencer (
        .clk(clk), .rst(rst), .line_strobe(hd), .field_strobe(vd),
        .region_active(reg_act), .cfg_total_reps(total), .cfg_alt_en(en),
        .cfg_idx_b(ib), .cfg_idx_c(ic), .cfg_idx_d(id),
        .pat_id(pat_id), .rep_num(rep_num), .rep_start(rep_start)
    );

    always #2.5 clk = ~clk;

    // expected pattern code for repetition n (R3, R7, R8, R9)
    function automatic int exp_pat(int n);
        int slot;
        int ix;
        slot = -1;
        for (int i = 2; i >= 0; i--) if (en[i]) slot = i;
        if (slot < 0) return 1;
        ix = (slot == 0) ? int'(ib) : (slot == 1) ? int'(ic) : int'(id);
        if (ix != 0 && ix == n && ix <= int'(total)) return 2 + slot;
        return 1;
    endfunction

    task automatic check(int act, int exp, string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit iss;
        if (rst || vd || !reg_act) begin
            m_armed = 1; m_cnt = 0; m_pat = 0; m_st = 0;
        end else begin
            m_st = 0;
            if (hd) begin
                if (m_armed) iss = (total != 0);
                else         iss = (m_cnt < int'(total));
                m_armed = 0;
                if (iss) m_cnt = m_cnt + 1;
                m_pat = iss ? exp_pat(m_cnt) : 0;
                m_st = iss;
            end
        end
    endtask

    task automatic cycle(bit h, bit v, bit r);
        hd = h; vd = v; reg_act = r;
        model_step();
        @(negedge clk);
        check(int'(rep_num), m_cnt, "R2 rep_num");
        check(int'(pat_id), m_pat, "R3 R6 pat_id");
        check(int'(rep_start), int'(m_st), "R5 rep_start");
        if (rep_start) begin
            pulses++;
            seen[int'(rep_num)] = int'(pat_id);
        end
    endtask

    task automatic run_region(int t, int e, int b, int c, int d, int nhd);
        total = W'(t); en = 3'(e); ib = W'(b); ic = W'(c); id = W'(d);
        pulses = 0;
        for (int i = 0; i < 16; i++) seen[i] = -1;
        cycle(0, 0, 1);
        cycle(0, 0, 1);
        for (int i = 0; i < nhd; i++) begin
            cycle(1, 0, 1);
            cycle(0, 0, 1);
        end
    endtask

    task automatic leave();
        cycle(0, 0, 0);
        cycle(0, 0, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1;
        cycle(0, 0, 0); cycle(1, 0, 1); cycle(0, 0, 1);
        check(int'(pat_id), 0, "R1 reset pat");
        check(int'(rep_num), 0, "R1 reset rep");
        check(int'(rep_start), 0, "R1 reset start");
        rst = 0;
        leave();

        // R7: B at repetition 4 of 6
        run_region(6, 3'b001, 4, 0, 0, 6);
        check(seen[4], 2, "R7 rep4 B");
        check(seen[3], 1, "R7 rep3 A");
        check(seen[5], 1, "R7 rep5 A");
        leave();

        // R8: C wins over D, D ignored
        run_region(5, 3'b110, 0, 2, 3, 5);
        check(seen[2], 3, "R8 rep2 C");
        check(seen[3], 1, "R8 rep3 not D");
        leave();
        // R8: B wins over C
        run_region(6, 3'b111, 5, 2, 4, 6);
        check(seen[5], 2, "R8 rep5 B");
        check(seen[2], 1, "R8 rep2 not C");
        check(seen[4], 1, "R8 rep4 not D");
        leave();

        // R9: index 0 and index past total
        run_region(4, 3'b001, 0, 0, 0, 4);
        check(seen[1], 1, "R9 idx0 rep1 A");
        leave();
        run_region(4, 3'b010, 0, 5, 0, 4);
        check(seen[4], 1, "R9 idx5 rep4 A");
        leave();

        // R4: exhaustion and zero total
        run_region(3, 3'b000, 0, 0, 0, 6);
        check(pulses, 3, "R4 pulse count");
        check(int'(rep_num), 3, "R4 rep holds total");
        check(int'(pat_id), 0, "R4 pat idle after total");
        leave();
        run_region(0, 3'b001, 1, 0, 0, 3);
        check(pulses, 0, "R4 zero total no pulse");
        check(int'(pat_id), 0, "R4 zero total idle");
        leave();

        // R10: field start restarts, region drop idles
        run_region(6, 3'b000, 0, 0, 0, 3);
        cycle(0, 1, 1);
        check(int'(rep_num), 0, "R10 vd clears rep");
        cycle(1, 0, 1);
        check(int'(rep_num), 1, "R10 restart rep1");
        check(int'(rep_start), 1, "R10 restart pulse");
        cycle(0, 0, 0);
        check(int'(pat_id), 0, "R10 drop idle");
        leave();

        // R6: no change between strobes
        run_region(5, 3'b001, 2, 0, 0, 2);
        for (int i = 0; i < 4; i++) cycle(0, 0, 1);
        check(int'(pat_id), 2, "R6 pat stable");
        check(int'(rep_num), 2, "R6 rep stable");
        leave();

        // random regions
        for (int r = 0; r < 60; r++) begin
            total = W'($urandom % 16);
            en = 3'($urandom % 8);
            ib = W'($urandom % 16); ic = W'($urandom % 16); id = W'($urandom % 16);
            cycle(0, 0, 1);
            for (int h = 0; h < int'(total) + 3; h++) begin
                cycle(1, (($urandom % 20) == 0) ? 1'b1 : 1'b0, 1);
                for (int g = 0; g < int'($urandom % 4); g++) cycle(0, 0, 1);
            end
            leave();
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule